// File: doc/BRIEF.md
# Postfix Stack Evaluation Engine

This block evaluates arithmetic and logical expressions written in postfix order, working like a zero-address machine. A command stream feeds it one command per cycle through a valid/ready handshake. A command pushes a 16-bit two's complement word, pops the top word out through a dedicated port, or applies a one-operand or two-operand operation to the top of the stack. The result replaces the operands on the stack.

The stack grows from a fixed base of zero entries up to a fixed limit of eight. The top and second entries sit in dedicated registers, so every operation finds both operands without a memory read. Deeper entries spill into a small array. When a pop or a two-operand operation takes an entry off the stack, the array refills the second-entry register in the same cycle.

A push onto a full stack is refused and flagged. A command that needs more operands than the stack holds is refused and flagged. A divide by zero is flagged and leaves zero as its result. All three flags describe the outcome of the most recently accepted command.

Top module: `stack_eval_unit`

## Requirements
- R1: While reset is held, the engine shows depth 0, top value 0, `cmd_ready` low, all three flags clear and `pop_valid` low. From the first cycle after reset is released, `cmd_ready` stays high.
- R2: An accepted command with op code 0 (push) adds one entry. After the clock edge, `tos_value` equals `cmd_data` and `depth` has gone up by one. All earlier entries are kept in last-in-first-out order.
- R3: An accepted op code 1 (pop) on a non-empty stack removes the top entry. In the next cycle, `pop_valid` is high for exactly one cycle and `pop_data` holds the removed value. The depth drops by one, and `tos_value` shows the entry that was below, even when that entry comes from the spill array.
- R4: An accepted push when `depth` is 8 sets `ovf_flag`. Depth and contents stay unchanged.
- R5: A command without enough operands sets `unf_flag` and changes nothing on the stack. This covers a pop on an empty stack, a one-operand operation on an empty stack, and a two-operand operation with fewer than two entries.
- R6: The two-operand op codes are 4 (add), 5 (subtract), 6 (multiply, low 16 bits of the product), 8 (bitwise AND) and 9 (bitwise OR). Each computes second OP top, replaces both entries with the result, and lowers the depth by one.
- R7: The one-operand op codes are 2 (two's complement negate) and 3 (bitwise NOT). Each replaces the top entry and leaves the depth unchanged.
- R8: Op code 7 divides second by top as signed values, truncating toward zero, and lowers the depth by one. When top is zero, it sets `dz_flag` and the result is 0.
- R9: Flags are updated only by accepted commands, and each accepted command clears the flags it does not set. Cycles with `cmd_valid` low change neither the flags nor the stack.
- R10: Op codes 10 to 15 are accepted as no-operation commands. They clear the flags and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 4 | Command op code |
| cmd_data | input | 16 | Word to push |
| tos_value | output | 16 | Current top entry (0 when empty) |
| depth | output | 4 | Number of entries held |
| pop_valid | output | 1 | One-cycle strobe for popped data |
| pop_data | output | 16 | Value removed by the last pop |
| ovf_flag | output | 1 | Last command pushed onto a full stack |
| unf_flag | output | 1 | Last command lacked operands |
| dz_flag | output | 1 | Last command divided by zero |

## Verification
A wrong spill pointer or a missed refill of the second-entry register stays hidden while the stack is shallow. It shows up only when a pop or a two-operand operation reaches below the second entry. For that reason, the stack is filled to its limit and drained, and expressions are evaluated on top of older entries. Each cycle's top value, depth and popped word are compared against a reference stack one edge after the command, so corruption is reported in the cycle it surfaces at the ports. Flag errors appear on the very next cycle and are checked on every accepted and idle cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_PUSH = 4'd0,
    OP_POP  = 4'd1,
    OP_NEG  = 4'd2,
    OP_NOT  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_MUL  = 4'd6,
    OP_DIV  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9
  } stk_op_e;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_PUSH,
    CLS_POP,
    CLS_UNARY,
    CLS_BINARY
  } stk_cls_e;

  function automatic stk_cls_e classify(input logic [3:0] op);
    case (op)
      OP_PUSH:                                   classify = CLS_PUSH;
      OP_POP:                                    classify = CLS_POP;
      OP_NEG, OP_NOT:                            classify = CLS_UNARY;
      OP_ADD, OP_SUB, OP_MUL, OP_DIV,
      OP_AND, OP_OR:                             classify = CLS_BINARY;
      default:                                   classify = CLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] top,
  output logic [W-1:0] res,
  output logic         div_zero
);
  import stk_pkg::*;

  localparam int PW = 2 * W;

  logic [PW-1:0]       prod;
  logic signed [W-1:0] quot;

  assign prod = PW'(sec) * PW'(top);

  always_comb begin
    quot = '0;
    if (top != '0) quot = $signed(sec) / $signed(top);
  end

  always_comb begin
    res      = top;
    div_zero = 1'b0;
    case (op)
      OP_NEG: res = '0 - top;
      OP_NOT: res = ~top;
      OP_ADD: res = sec + top;
      OP_SUB: res = sec - top;
      OP_MUL: res = prod[W-1:0];
      OP_DIV: begin
        div_zero = (top == '0);
        res      = div_zero ? '0 : quot;
      end
      OP_AND: res = sec & top;
      OP_OR:  res = sec | top;
      default: res = top;
    endcase
  end

endmodule

// File: rtl/stk_spill_mem.sv
module stk_spill_mem #(
  parameter int W       = 16,
  parameter int ENTRIES = 6,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/stack_eval_unit.sv
module stack_eval_unit #(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 8,
  parameter int PTR_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic [DATA_W-1:0] tos_value,
  output logic [PTR_W-1:0]  depth,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              dz_flag
);
  import stk_pkg::*;

  localparam int SPILL_N = STACK_DEPTH - 2;
  localparam int SP_AW   = (SPILL_N > 1) ? $clog2(SPILL_N) : 1;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(STACK_DEPTH);
  localparam logic [PTR_W-1:0] ONE   = PTR_W'(1);
  localparam logic [PTR_W-1:0] TWO   = PTR_W'(2);
  localparam logic [PTR_W-1:0] THREE = PTR_W'(3);

  logic [DATA_W-1:0] top_q, sec_q, pd_q;
  logic [PTR_W-1:0]  depth_q;
  logic              rdy_q, pv_q, ovf_q, unf_q, dz_q;

  logic [DATA_W-1:0] nxt_top, nxt_sec, nxt_pd;
  logic [PTR_W-1:0]  nxt_depth;
  logic              nxt_pv, nxt_ovf, nxt_unf, nxt_dz;

  logic              accept;
  stk_cls_e          cls;
  logic [DATA_W-1:0] alu_res, spill_rd, refill;
  logic              alu_dz, spill_we;
  logic [PTR_W-1:0]  wptr, rptr;

  assign accept = cmd_valid && rdy_q;
  assign cls    = classify(cmd_op);
  assign wptr   = depth_q - TWO;
  assign rptr   = depth_q - THREE;

  assign spill_we = accept && (cls == CLS_PUSH) && (depth_q >= TWO) && (depth_q != LIMIT);
  assign refill   = (depth_q >= THREE) ? spill_rd : '0;

  stk_alu #(.W(DATA_W)) u_alu (
    .op       (cmd_op),
    .sec      (sec_q),
    .top      (top_q),
    .res      (alu_res),
    .div_zero (alu_dz)
  );

  stk_spill_mem #(.W(DATA_W), .ENTRIES(SPILL_N), .AW(SP_AW)) u_spill (
    .clk   (clk),
    .we    (spill_we),
    .waddr (wptr[SP_AW-1:0]),
    .wdata (sec_q),
    .raddr (rptr[SP_AW-1:0]),
    .rdata (spill_rd)
  );

  always_comb begin
    nxt_top   = top_q;
    nxt_sec   = sec_q;
    nxt_depth = depth_q;
    nxt_pd    = pd_q;
    nxt_pv    = 1'b0;
    nxt_ovf   = ovf_q;
    nxt_unf   = unf_q;
    nxt_dz    = dz_q;
    if (accept) begin
      nxt_ovf = 1'b0;
      nxt_unf = 1'b0;
      nxt_dz  = 1'b0;
      case (cls)
        CLS_PUSH: begin
          if (depth_q == LIMIT) nxt_ovf = 1'b1;
          else begin
            nxt_sec   = top_q;
            nxt_top   = cmd_data;
            nxt_depth = depth_q + ONE;
          end
        end
        CLS_POP: begin
          if (depth_q == '0) nxt_unf = 1'b1;
          else begin
            nxt_pv    = 1'b1;
            nxt_pd    = top_q;
            nxt_top   = sec_q;
            nxt_sec   = refill;
            nxt_depth = depth_q - ONE;
          end
        end
        CLS_UNARY: begin
          if (depth_q == '0) nxt_unf = 1'b1;
          else nxt_top = alu_res;
        end
        CLS_BINARY: begin
          if (depth_q < TWO) nxt_unf = 1'b1;
          else begin
            nxt_top   = alu_res;
            nxt_sec   = refill;
            nxt_depth = depth_q - ONE;
            nxt_dz    = alu_dz;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q   <= '0;
      sec_q   <= '0;
      pd_q    <= '0;
      depth_q <= '0;
      rdy_q   <= 1'b0;
      pv_q    <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      top_q   <= nxt_top;
      sec_q   <= nxt_sec;
      pd_q    <= nxt_pd;
      depth_q <= nxt_depth;
      rdy_q   <= 1'b1;
      pv_q    <= nxt_pv;
      ovf_q   <= nxt_ovf;
      unf_q   <= nxt_unf;
      dz_q    <= nxt_dz;
    end
  end

  assign cmd_ready = rdy_q;
  assign tos_value = top_q;
  assign depth     = depth_q;
  assign pop_valid = pv_q;
  assign pop_data  = pd_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;
  assign dz_flag   = dz_q;

  // R2 / R4: depth never exceeds the limit
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth <= LIMIT);

  // R4: push on a full stack is refused and flagged
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 4'd0 && depth == LIMIT)
    |=> (ovf_flag && depth == LIMIT && tos_value == $past(tos_value)));

  // R5: pop on an empty stack is refused and flagged
  a_r5_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 4'd1 && depth == '0)
    |=> (unf_flag && !pop_valid && depth == '0));

  // R3: a pop delivers the old top on the data port
  a_r3_pop_data: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 4'd1 && depth != '0)
    |=> (pop_valid && pop_data == $past(tos_value) && depth == $past(depth) - ONE));

  // R6: a two-operand operation leaves one entry fewer
  a_r6_binary_depth: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && classify(cmd_op) == CLS_BINARY && depth >= TWO)
    |=> (depth == $past(depth) - ONE && !unf_flag));

  // R8: divide by zero flags and leaves zero
  a_r8_div_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 4'd7 && depth >= TWO && tos_value == '0)
    |=> (dz_flag && tos_value == '0));

  // R9: idle cycles leave the stack and flags alone
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && cmd_ready)
    |=> ($stable(depth) && $stable(tos_value) && $stable(ovf_flag) && $stable(unf_flag) && $stable(dz_flag) && !pop_valid));

  // R4 / R5 / R8: the flags never report two outcomes at once
  a_r9_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_flag, unf_flag, dz_flag}));

endmodule

// File: tb/stack_eval_unit_bench.sv
`timescale 1ns/1ps
module stack_eval_unit_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [3:0]   cmd_op = 4'd0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] tos_value;
  logic [3:0]   depth;
  logic         pop_valid;
  logic [W-1:0] pop_data;
  logic         ovf_flag, unf_flag, dz_flag;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  stack_eval_unit u_stack_eval_unit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .tos_value(tos_value), .depth(depth),
    .pop_valid(pop_valid), .pop_data(pop_data), .ovf_flag(ovf_flag),
    .unf_flag(unf_flag), .dz_flag(dz_flag)
  );

  typedef struct {
    logic [W-1:0] tos;
    int           dep;
    bit           ovf, unf, dz, pv;
    logic [W-1:0] pd;
    string        tag;
  } exp_t;

  exp_t         exp_q[$];
  logic [W-1:0] mdl[$];
  bit           m_ovf, m_unf, m_dz;
  logic [W-1:0] m_pd = '0;

  task automatic chk(input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: compare one edge after each driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "tos_value", tos_value, e.tos);
      chk(e.tag, "depth", depth, e.dep);
      chk(e.tag, "ovf_flag", ovf_flag, e.ovf);
      chk(e.tag, "unf_flag", unf_flag, e.unf);
      chk(e.tag, "dz_flag", dz_flag, e.dz);
      chk(e.tag, "pop_valid", pop_valid, e.pv);
      if (e.pv) chk(e.tag, "pop_data", pop_data, e.pd);
      chk(e.tag, "cmd_ready", cmd_ready, 1);
    end
  end

  function automatic logic [W-1:0] mtop();
    return (mdl.size() > 0) ? mdl[mdl.size()-1] : '0;
  endfunction

  // driver: apply a command and queue the expected result
  task automatic issue(input bit vld, input logic [3:0] op, input logic [W-1:0] data, input string tag);
    exp_t e;
    bit pv = 0;
    @(negedge clk);
    cmd_valid = vld;
    cmd_op    = op;
    cmd_data  = data;
    if (vld) begin
      m_ovf = 0; m_unf = 0; m_dz = 0;
      case (op)
        4'd0: if (mdl.size() == 8) m_ovf = 1; else mdl.push_back(data);
        4'd1: if (mdl.size() == 0) m_unf = 1;
              else begin m_pd = mdl.pop_back(); pv = 1; end
        4'd2, 4'd3: if (mdl.size() == 0) m_unf = 1;
              else begin
                logic [W-1:0] t;
                t = mdl.pop_back();
                mdl.push_back(op == 4'd2 ? W'(-int'(t)) : ~t);
              end
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: if (mdl.size() < 2) m_unf = 1;
              else begin
                logic [W-1:0] b, a, r;
                longint p;
                b = mdl.pop_back();
                a = mdl.pop_back();
                r = '0;
                case (op)
                  4'd4: r = W'(int'(a) + int'(b));
                  4'd5: r = W'(int'(a) - int'(b));
                  4'd6: begin p = longint'(a) * longint'(b); r = p[W-1:0]; end
                  4'd7: if (b == 0) m_dz = 1;
                        else r = W'(int'($signed(a)) / int'($signed(b)));
                  4'd8: r = a & b;
                  default: r = a | b;
                endcase
                mdl.push_back(r);
              end
        default: ;
      endcase
    end
    e.tos = mtop(); e.dep = mdl.size();
    e.ovf = m_ovf; e.unf = m_unf; e.dz = m_dz; e.pv = pv; e.pd = m_pd; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "depth", depth, 0);
    chk("R1", "tos_value", tos_value, 0);
    chk("R1", "cmd_ready", cmd_ready, 0);
    chk("R1", "flags", {ovf_flag, unf_flag, dz_flag, pop_valid}, 0);
    @(negedge clk); rst = 1'b0;
    issue(0, 0, 0, "R1");
    // R5 underflow cases
    issue(1, 4'd1, 0, "R5");
    issue(1, 4'd4, 0, "R5");
    issue(1, 4'd2, 0, "R5");
    issue(1, 4'd0, 16'd5, "R2");
    issue(1, 4'd5, 0, "R5");
    // R6 binary operations
    issue(1, 4'd0, 16'd3, "R2");
    issue(1, 4'd5, 0, "R6");
    issue(1, 4'd0, 16'd7, "R2");
    issue(1, 4'd6, 0, "R6");
    issue(1, 4'd0, 16'hFFF0, "R2");
    issue(1, 4'd8, 0, "R6");
    issue(1, 4'd0, 16'h0F0F, "R2");
    issue(1, 4'd9, 0, "R6");
    issue(1, 4'd0, 16'h8001, "R2");
    issue(1, 4'd6, 0, "R6");
    issue(1, 4'd0, 16'hFFFF, "R2");
    issue(1, 4'd4, 0, "R6");
    // R7 unary operations
    issue(1, 4'd2, 0, "R7");
    issue(1, 4'd3, 0, "R7");
    // R8 division
    issue(1, 4'd0, 16'hFFF9, "R2");
    issue(1, 4'd0, 16'd2, "R2");
    issue(1, 4'd7, 0, "R8");
    issue(1, 4'd0, 16'd0, "R2");
    issue(1, 4'd7, 0, "R8");
    // R9 idle keeps flags and stack
    issue(0, 4'd1, 0, "R9");
    issue(0, 4'd0, 16'h1234, "R9");
    // R10 unused op codes
    issue(1, 4'd12, 0, "R10");
    issue(1, 4'd1, 0, "R3");
    issue(1, 4'd1, 0, "R3");
    issue(1, 4'd15, 0, "R10");
    issue(1, 4'd1, 0, "R5");
    issue(1, 4'd10, 0, "R10");
    // R4 fill to limit, overflow, then drain in order (R3)
    for (int i = 0; i < 8; i++) issue(1, 4'd0, W'(16'h100 + i * 16'h11), "R2");
    issue(1, 4'd0, 16'hDEAD, "R4");
    issue(0, 4'd0, 0, "R9");
    issue(1, 4'd0, 16'hBEEF, "R4");
    for (int i = 0; i < 8; i++) issue(1, 4'd1, 0, "R3");
    issue(1, 4'd1, 0, "R5");
    // R6 expression (a-b)/(c+d*e) above older entries, with refill
    issue(1, 4'd0, 16'd100, "R2");
    issue(1, 4'd0, 16'd200, "R2");
    issue(1, 4'd0, 16'd300, "R2");
    issue(1, 4'd0, 16'd90, "R2");
    issue(1, 4'd0, 16'd6, "R2");
    issue(1, 4'd5, 0, "R6");
    issue(1, 4'd0, 16'd4, "R2");
    issue(1, 4'd0, 16'd2, "R2");
    issue(1, 4'd0, 16'd3, "R2");
    issue(1, 4'd6, 0, "R6");
    issue(1, 4'd4, 0, "R6");
    issue(1, 4'd7, 0, "R8");
    issue(1, 4'd4, 0, "R6");
    issue(1, 4'd5, 0, "R6");
    issue(1, 4'd1, 0, "R3");
    issue(1, 4'd1, 0, "R3");
    issue(0, 4'd0, 0, "R9");
    repeat (3) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule